// File: doc/BRIEF.md
# Programmable AND-OR logic array

This block is the logic core of a small field-configurable device. Twelve dedicated inputs and ten feedback signals from the I/O cells each give two array lines: the signal itself and its inverse. Each product term is a wide AND over whichever of those lines its configuration bits select. A fixed OR plane then combines uneven groups of product terms into ten sum outputs. The same array also produces one enable term per I/O cell and two global terms, one for preset and one for clear. The I/O cell block that consumes these terms handles registers and polarity.

The connection map is loaded before use through a one-bit serial port, with one bit taken on each clock while the load enable is high. After the last bit of the map arrives, a done flag goes high. All array outputs are held low until then. From the inputs to the term and sum outputs the logic is purely combinational. The configuration storage is the only state in the block.

Top module: `pla_core`

## Requirements
- R1: Array line 2*i is dedicated input i and line 2*i+1 is its inverse, for i in 0..11. Line 24+2*j is feedback j and line 25+2*j is its inverse, for j in 0..9.
- R2: Configuration stream bit k (counted from 0) is the connection bit for line k mod 44 of product term k div 44. A product term is the AND of every line whose connection bit is 1.
- R3: A product term connected to both a line and its inverse is always 0.
- R4: A product term with no connection bits set is always 1.
- R5: Sum outputs 0 to 9 OR together 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 consecutive product terms, taken in output order starting at term 0, so the sum terms are 0..119.
- R6: Terms 120..129 are the enable terms of outputs 0..9 in order. Term 130 is the global preset term and term 131 is the global clear term.
- R7: Each clock with the load enable high shifts in one configuration bit. The done flag rises on the edge that takes the 5808th bit and does not change on a clock without load enable.
- R8: While the done flag is low, including after the asynchronous reset, every sum, enable, preset and clear output is 0.
- R9: A bit loaded while the done flag is high starts a new map. That bit becomes stream bit 0, and the done flag is low after that edge.
- R10: Once loaded, the outputs follow changes on the dedicated and feedback inputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load enable for the serial map |
| cfg_bit_i | input | 1 | Serial configuration bit |
| ded_i | input | 12 | Dedicated inputs |
| fb_i | input | 10 | Feedback signals from the I/O cells |
| sum_o | output | 10 | Sum-of-products outputs |
| oe_term_o | output | 10 | Per-output enable terms |
| preset_term_o | output | 1 | Global preset term |
| clear_term_o | output | 1 | Global clear term |
| cfg_done_o | output | 1 | Map fully loaded |

## Verification
The assertions sample the combinational outputs at clock edges. They therefore assume that the dedicated and feedback inputs and the serial load pins are known and settled at each rising edge. The stability check further assumes that the outputs change only when those inputs change or when a configuration bit was taken at the previous edge.

The stimulus changes every input just after a falling edge. It holds the load enable at a defined level on every cycle, so both conditions hold. Checks of combinational behaviour also happen between edges, after a short settling delay.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;

  // lines per array: true and inverse of every input
  function automatic int lines_total(input int n_ded, input int n_fb);
    return 2 * (n_ded + n_fb);
  endfunction

  // terms for output o: grow by step toward the middle, mirror afterwards
  function automatic int terms_of(input int o, input int n_out, input int base, input int step);
    int d;
    d = (o < (n_out - 1 - o)) ? o : (n_out - 1 - o);
    return base + step * d;
  endfunction

  // first term index of output o
  function automatic int term_first(input int o, input int n_out, input int base, input int step);
    int acc;
    acc = 0;
    for (int i = 0; i < o; i++) acc += terms_of(i, n_out, base, step);
    return acc;
  endfunction

  function automatic int sum_terms_total(input int n_out, input int base, input int step);
    return term_first(n_out, n_out, base, step);
  endfunction

endpackage

// File: rtl/pla_cfg_shift.sv
`timescale 1ns/1ps
module pla_cfg_shift #(
  parameter int MAP_BITS = 5808
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                bit_i,
  output logic [MAP_BITS-1:0] map_o,
  output logic                done_o
);
  localparam int CNT_W = $clog2(MAP_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAP_BITS - 1);

  logic [MAP_BITS-1:0] map_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                done_q;

  // first streamed bit settles at index 0 after a full load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (load_i) begin
      map_q <= {bit_i, map_q[MAP_BITS-1:1]};
      if (done_q) begin
        done_q <= 1'b0;
        cnt_q  <= CNT_W'(1);
      end else if (cnt_q == LAST) begin
        done_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign map_o  = map_q;
  assign done_o = done_q;
endmodule

// File: rtl/pla_line_drv.sv
`timescale 1ns/1ps
module pla_line_drv #(
  parameter int N_DED = 12,
  parameter int N_FB  = 10,
  localparam int N_LINES = pla_pkg::lines_total(N_DED, N_FB)
) (
  input  logic [N_DED-1:0]   ded_i,
  input  logic [N_FB-1:0]    fb_i,
  output logic [N_LINES-1:0] lines_o
);
  for (genvar i = 0; i < N_DED; i++) begin : g_ded
    assign lines_o[2*i]   = ded_i[i];
    assign lines_o[2*i+1] = ~ded_i[i];
  end

  for (genvar j = 0; j < N_FB; j++) begin : g_fb
    assign lines_o[2*N_DED+2*j]   = fb_i[j];
    assign lines_o[2*N_DED+2*j+1] = ~fb_i[j];
  end
endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
  parameter int N_LINES = 44,
  parameter int N_TERMS = 132,
  localparam int MAP_BITS = N_LINES * N_TERMS
) (
  input  logic [N_LINES-1:0]  lines_i,
  input  logic [MAP_BITS-1:0] map_i,
  output logic [N_TERMS-1:0]  terms_o
);
  // open crossing passes 1; closed crossing passes the line
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [N_LINES-1:0] conn;
    assign conn       = map_i[t*N_LINES +: N_LINES];
    assign terms_o[t] = &(~conn | lines_i);
  end
endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
  parameter int N_OUT      = 10,
  parameter int TERM_BASE  = 8,
  parameter int TERM_STEP  = 2,
  localparam int N_SUM     = pla_pkg::sum_terms_total(N_OUT, TERM_BASE, TERM_STEP)
) (
  input  logic [N_SUM-1:0] terms_i,
  output logic [N_OUT-1:0] sum_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    localparam int FIRST = pla_pkg::term_first(o, N_OUT, TERM_BASE, TERM_STEP);
    localparam int CNT   = pla_pkg::terms_of(o, N_OUT, TERM_BASE, TERM_STEP);
    assign sum_o[o] = |terms_i[FIRST +: CNT];
  end
endmodule

// File: rtl/pla_core.sv
`timescale 1ns/1ps
module pla_core #(
  parameter int N_DED     = 12,
  parameter int N_FB      = 10,
  parameter int TERM_BASE = 8,
  parameter int TERM_STEP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_load_i,
  input  logic             cfg_bit_i,
  input  logic [N_DED-1:0] ded_i,
  input  logic [N_FB-1:0]  fb_i,
  output logic [N_FB-1:0]  sum_o,
  output logic [N_FB-1:0]  oe_term_o,
  output logic             preset_term_o,
  output logic             clear_term_o,
  output logic             cfg_done_o
);
  localparam int N_LINES  = pla_pkg::lines_total(N_DED, N_FB);
  localparam int N_SUM    = pla_pkg::sum_terms_total(N_FB, TERM_BASE, TERM_STEP);
  localparam int N_TERMS  = N_SUM + N_FB + 2;
  localparam int MAP_BITS = N_LINES * N_TERMS;
  localparam int IDX_PRE  = N_SUM + N_FB;
  localparam int IDX_CLR  = N_SUM + N_FB + 1;

  logic [MAP_BITS-1:0] map;
  logic                done;
  logic [N_LINES-1:0]  lines;
  logic [N_TERMS-1:0]  terms;
  logic [N_FB-1:0]     sum_raw;

  pla_cfg_shift #(.MAP_BITS(MAP_BITS)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .bit_i  (cfg_bit_i),
    .map_o  (map),
    .done_o (done)
  );

  pla_line_drv #(.N_DED(N_DED), .N_FB(N_FB)) i_lines (
    .ded_i   (ded_i),
    .fb_i    (fb_i),
    .lines_o (lines)
  );

  pla_and_plane #(.N_LINES(N_LINES), .N_TERMS(N_TERMS)) i_and (
    .lines_i (lines),
    .map_i   (map),
    .terms_o (terms)
  );

  pla_or_plane #(.N_OUT(N_FB), .TERM_BASE(TERM_BASE), .TERM_STEP(TERM_STEP)) i_or (
    .terms_i (terms[N_SUM-1:0]),
    .sum_o   (sum_raw)
  );

  // partial maps never reach the I/O cells
  assign sum_o         = done ? sum_raw : '0;
  assign oe_term_o     = done ? terms[N_SUM +: N_FB] : '0;
  assign preset_term_o = done & terms[IDX_PRE];
  assign clear_term_o  = done & terms[IDX_CLR];
  assign cfg_done_o    = done;
endmodule

// File: rtl/pla_core_chk.sv
`timescale 1ns/1ps
module pla_core_chk #(
  parameter int N_DED = 12,
  parameter int N_FB  = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_load_i,
  input logic             cfg_bit_i,
  input logic [N_DED-1:0] ded_i,
  input logic [N_FB-1:0]  fb_i,
  input logic [N_FB-1:0]  sum_o,
  input logic [N_FB-1:0]  oe_term_o,
  input logic             preset_term_o,
  input logic             clear_term_o,
  input logic             cfg_done_o
);
  assert_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_o |-> (sum_o == '0 && oe_term_o == '0 && !preset_term_o && !clear_term_o));

  assert_done_needs_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_done_o) |-> $past(cfg_load_i));

  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load_i |=> $stable(cfg_done_o));

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_load_i && cfg_done_o) |=> !cfg_done_o);

  assert_comb_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cfg_load_i) && $stable(ded_i) && $stable(fb_i))
      |-> ($stable(sum_o) && $stable(oe_term_o) && $stable(preset_term_o) && $stable(clear_term_o)));

  // serial bit is only meaningful with load enable; it must be known then
  assert_bit_known_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |-> !$isunknown(cfg_bit_i));
endmodule

bind pla_core pla_core_chk #(.N_DED(N_DED), .N_FB(N_FB)) i_pla_core_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_load_i    (cfg_load_i),
  .cfg_bit_i     (cfg_bit_i),
  .ded_i         (ded_i),
  .fb_i          (fb_i),
  .sum_o         (sum_o),
  .oe_term_o     (oe_term_o),
  .preset_term_o (preset_term_o),
  .clear_term_o  (clear_term_o),
  .cfg_done_o    (cfg_done_o)
);

// File: tb/test_pla_core.sv
`timescale 1ns/1ps
module test_pla_core;
  localparam int ND = 12;
  localparam int NF = 10;
  localparam int NL = 44;
  localparam int NT = 132;
  localparam int MB = NL * NT;
  localparam int CNTS [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          load;
  logic          bitv;
  logic [ND-1:0] ded;
  logic [NF-1:0] fb;
  logic [NF-1:0] sum_o;
  logic [NF-1:0] oe_o;
  logic          pre_o;
  logic          clr_o;
  logic          done_o;

  pla_core i_pla_core (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cfg_load_i    (load),
    .cfg_bit_i     (bitv),
    .ded_i         (ded),
    .fb_i          (fb),
    .sum_o         (sum_o),
    .oe_term_o     (oe_o),
    .preset_term_o (pre_o),
    .clear_term_o  (clr_o),
    .cfg_done_o    (done_o)
  );

  int checks = 0;
  int errors = 0;

  // reference model: stream position and stored bits
  bit ref_map [MB];
  int ref_k;
  bit ref_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_k    = 0;
      ref_done = 1'b0;
    end else if (load) begin
      if (ref_done) begin
        ref_map[0] = bitv;
        ref_k      = 1;
        ref_done   = 1'b0;
      end else begin
        ref_map[ref_k] = bitv;
        if (ref_k == MB - 1) begin
          ref_done = 1'b1;
          ref_k    = 0;
        end else begin
          ref_k++;
        end
      end
    end
  end

  function automatic bit line_val(int l);
    if (l < 2 * ND) return ded[l/2] ^ bit'(l % 2);
    return fb[(l - 2*ND)/2] ^ bit'(l % 2);
  endfunction

  function automatic bit term_val(int t);
    for (int l = 0; l < NL; l++)
      if (ref_map[t*NL + l] && !line_val(l)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0h exp=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [NF-1:0] e_sum;
    logic [NF-1:0] e_oe;
    bit e_pre;
    bit e_clr;
    int first;
    e_sum = '0; e_oe = '0; e_pre = 0; e_clr = 0;
    if (ref_done) begin
      first = 0;
      for (int o = 0; o < NF; o++) begin
        for (int t = first; t < first + CNTS[o]; t++) e_sum[o] = e_sum[o] | term_val(t);
        first += CNTS[o];
        e_oe[o] = term_val(120 + o);
      end
      e_pre = term_val(130);
      e_clr = term_val(131);
    end
    chk(sum_o == e_sum, "R1 R2 R5 R8", "sum", int'(sum_o), int'(e_sum));
    chk(oe_o == e_oe, "R6 R8", "oe", int'(oe_o), int'(e_oe));
    chk({pre_o, clr_o} == {e_pre, e_clr}, "R6 R8", "preset/clear", int'({pre_o, clr_o}), int'({e_pre, e_clr}));
    chk(done_o == ref_done, "R7", "done", int'(done_o), int'(ref_done));
  endtask

  function automatic bit gen_bit(int seed, int k);
    int t;
    int l;
    int unsigned h;
    t = k / NL;
    l = k % NL;
    if (seed == 1) begin
      if (t < 8) return 1'b0;                                // R4: output 0 always 1
      if (t >= 112 && t <= 118) return (l == 0 || l == 1);   // R3 conflicts
      if (t == 119) return (l == 2);                         // sum 9 = ded[1]
      if (t == 120) return (l == 1 || l == 26);              // oe0 = !ded[0] & fb[1]
      if (t == 121) return (l == 0 || l == 1 || l == 5);     // R3
      if (t == 130) return (l == 24 || l == 25);             // R3
      if (t == 131) return 1'b0;                             // R4
    end
    h = 32'(t * 1103 + l * 7919 + seed * 104729);
    h = h ^ (h >> 7);
    h = h * 32'd2654435761;
    return ((h >> 20) % 13) == 0;
  endfunction

  task automatic load_map(int seed, int start_k);
    for (int k = start_k; k < MB; k++) begin
      load = 1'b1;
      bitv = gen_bit(seed, k);
      @(negedge clk);
      check_all();
    end
    load = 1'b0;
  endtask

  task automatic run_random(int n);
    for (int i = 0; i < n; i++) begin
      ded = ND'($urandom);
      fb  = NF'($urandom);
      #1;
      check_all();  // R10: no edge since the change
      @(negedge clk);
      check_all();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load = 1'b0; bitv = 1'b0; ded = '0; fb = '0;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R8", "reset done", int'(done_o), 0);
    chk({sum_o, oe_o, pre_o, clr_o} == '0, "R8", "reset outputs", int'({sum_o, oe_o}), 0);
    rst_n = 1'b1;
    ded = ND'($urandom); fb = NF'($urandom);
    @(negedge clk);
    check_all();
    // R7: no clock with load enable means no progress
    chk(done_o == 1'b0, "R7", "idle done", int'(done_o), 0);

    load_map(1, 0);
    chk(done_o == 1'b1, "R7", "done after full map", int'(done_o), 1);

    // directed term checks on map 1
    ded = ND'($urandom); fb = NF'($urandom);
    #1;
    chk(sum_o[0] == 1'b1, "R4", "empty terms sum0", int'(sum_o[0]), 1);
    chk(clr_o == 1'b1, "R4", "empty clear term", int'(clr_o), 1);
    chk(oe_o[1] == 1'b0, "R3", "conflict oe1", int'(oe_o[1]), 0);
    chk(pre_o == 1'b0, "R3", "conflict preset", int'(pre_o), 0);
    for (int v = 0; v < 4; v++) begin
      ded[0] = v[0]; fb[1] = v[1]; ded[1] = v[0] ^ v[1];
      #1;
      chk(oe_o[0] == (!v[0] && v[1]), "R1 R2 R6", "oe0 term", int'(oe_o[0]), int'(!v[0] && v[1]));
      chk(sum_o[9] == (v[0] ^ v[1]), "R5", "sum9 last term", int'(sum_o[9]), int'(v[0] ^ v[1]));
    end
    @(negedge clk);
    check_all();
    run_random(300);

    // R9: a bit while done starts a new map
    load = 1'b1;
    bitv = gen_bit(2, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R9", "restart done", int'(done_o), 0);
    chk({sum_o, oe_o, pre_o, clr_o} == '0, "R8 R9", "outputs during reload", int'({sum_o, oe_o}), 0);
    check_all();
    load_map(2, 1);
    run_random(300);

    // asynchronous reset mid-operation
    #1 rst_n = 1'b0;
    #1;
    chk(done_o == 1'b0, "R8", "async reset done", int'(done_o), 0);
    chk({sum_o, oe_o, pre_o, clr_o} == '0, "R8", "async reset outputs", int'({sum_o, oe_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    load_map(3, 0);
    run_random(200);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule